// File: doc/BRIEF.md
# Drift Hit Time-Bin Encoder

This block turns discriminated wire signals from one drift chamber readout channel into a compact timing code. Each beam crossing opens a window. Within that window, the leading edge of every wire pulse is stamped against a free-running fine-time count and placed in one of several programmable time bins. When the last bin closes, the block presents a registered occupancy word, with one bit per wire per bin, together with a single-cycle valid pulse.

A real pulse is longer than one bin, so a wire that has already fired in one bin could fire again just after the next bin opens. A short programmable "uncertain" interval at the start of every bin except the first discards such an edge when the same wire already holds the preceding bin.

A configuration input selects one of two modes. Full mode uses six bins. Legacy mode uses only the first two bins and forces the rest to zero. The start and stop of every bin, and the length of the uncertain interval, are configuration inputs expressed in fine-time ticks.

Top module: `drift_bin_encoder`

## Requirements
- R1: While reset is held and after it is released, `occ_valid` is 0 and `occ_word` is all zeros until the first window closes.
- R2: Only a rising edge of a wire counts. A level that is already high when the window opens adds nothing. A pulse that stays high across several bins sets only the bin in which its edge fell. Two edges of one wire in the same bin set that bit once.
- R3: An edge stamped at tick t sets bit `b*NUM_WIRES + w` of the word when `bin_start[b] <= t < bin_stop[b]`. Bin b's start and stop are the TW-bit fields at `b*TW` of `cfg_bin_start` and `cfg_bin_stop`.
- R4: Tick 0 is the first clock cycle after the cycle in which `xing_strobe` is high. The tick is `fine_time` minus (the strobe-cycle `fine_time` + 1), modulo 2^TW, so it is unaffected when `fine_time` wraps. An edge is stamped with the tick two cycles after the cycle in which the raw input first reads high, because it passes through a two-flop synchronizer.
- R5: For bin b >= 1, an edge with `bin_start[b] <= t < bin_start[b] + cfg_unsure_len` is dropped if the same wire already has bin b-1 set. The same edge is recorded when bin b-1 is clear. An edge at or after the end of the interval is always recorded.
- R6: Edges stamped outside every active bin, or while no window is open, change no bit.
- R7: The window closes in the cycle whose tick first reaches the stop of the last active bin. `occ_valid` is then high for exactly one cycle, at tick close+1, with the new word. No valid pulse appears unless a strobe was seen.
- R8: With `cfg_legacy` = 1, only bins 0 and 1 are used. The window closes at `bin_stop[1]`, and the word bits for bins 2 to 5 are zero.
- R9: A strobe that arrives while a window is open discards what has been collected and starts a new window. The abandoned window produces no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine-time clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_legacy | input | 1 | 1 selects two-bin mode, 0 selects full six-bin mode |
| cfg_bin_start | input | NUM_BINS*TW | First tick of each bin, bin b at bits b*TW |
| cfg_bin_stop | input | NUM_BINS*TW | First tick past each bin, bin b at bits b*TW |
| cfg_unsure_len | input | TW | Length in ticks of the uncertain interval at each bin start |
| fine_time | input | TW | Free-running fine-time count |
| xing_strobe | input | 1 | Crossing marker that opens a window |
| wire_hit | input | NUM_WIRES | Raw discriminated wire levels, asynchronous |
| occ_word | output | NUM_BINS*NUM_WIRES | Bin occupancy, bit b*NUM_WIRES+w |
| occ_valid | output | 1 | One-cycle pulse when a new word is presented |

## Verification
A basic full-mode window places single edges on both sides of every kind of boundary: before the first bin, on a bin start, one tick before a bin stop, and on the closing tick. This separates off-by-one errors in bin matching from errors in the closing rule, and it starts `fine_time` near its top value so the tick subtraction wraps. A second pattern places pairs of edges on one wire inside, just past, and without a predecessor in the uncertain interval, which tells the suppression rule apart from plain binning. Held levels, long pulses and repeated edges in one bin show that only rising edges count. A legacy-mode window and a strobe that restarts an open window check the mode masking and the discard path.

// File: rtl/drift_bin_pkg.sv
package drift_bin_pkg;

    // Width used by the tick comparison helpers; module tick widths must not exceed it
    localparam int TICK_W = 16;

    // Number of bins used in two-bin compatibility mode
    localparam int LEGACY_BINS = 2;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    // Half-open interval membership: lo <= t < hi
    function automatic logic tick_in_span(
        input logic [TICK_W-1:0] t,
        input logic [TICK_W-1:0] lo,
        input logic [TICK_W-1:0] hi
    );
        return (t >= lo) && (t < hi);
    endfunction

    // Membership in the uncertain interval at the start of a bin; one extra bit avoids overflow
    function automatic logic tick_in_unsure(
        input logic [TICK_W-1:0] t,
        input logic [TICK_W-1:0] lo,
        input logic [TICK_W-1:0] len
    );
        logic [TICK_W:0] lim;
        lim = {1'b0, lo} + {1'b0, len};
        return (t >= lo) && ({1'b0, t} < lim);
    endfunction

endpackage

// File: rtl/dbe_hit_sync.sv
module dbe_hit_sync #(
    parameter int NUM_WIRES = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WIRES-1:0] raw_in,
    output logic [NUM_WIRES-1:0] rise
);

    logic [NUM_WIRES-1:0] meta_q;
    logic [NUM_WIRES-1:0] sync_q;
    logic [NUM_WIRES-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q & ~last_q;

    // A single synchronized pulse never yields edges on consecutive cycles
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0)); // R2

endmodule

// File: rtl/dbe_bin_window.sv
module dbe_bin_window
    import drift_bin_pkg::*;
#(
    parameter int NUM_BINS = 6,
    parameter int TW       = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   strobe,
    input  logic                   cfg_legacy,
    input  logic [TW-1:0]          fine_time,
    input  logic [NUM_BINS*TW-1:0] cfg_bin_start,
    input  logic [NUM_BINS*TW-1:0] cfg_bin_stop,
    input  logic [TW-1:0]          cfg_unsure_len,
    output logic                   win_open,
    output logic                   win_close,
    output logic [NUM_BINS-1:0]    bin_hit,
    output logic [NUM_BINS-1:0]    bin_unsure
);

    localparam int PW       = TICK_W;
    localparam int LAST_ALL = NUM_BINS - 1;
    localparam int LAST_LEG = LEGACY_BINS - 1;

    win_state_e    state_q;
    logic [TW-1:0] base_q;
    logic [TW-1:0] elapsed;
    logic [TW-1:0] close_tick;
    logic          accept;

    // Tick 0 is the cycle right after the strobe cycle; modulo subtraction survives wrap
    assign elapsed    = fine_time - base_q;
    assign close_tick = cfg_legacy ? cfg_bin_stop[LAST_LEG*TW +: TW]
                                   : cfg_bin_stop[LAST_ALL*TW +: TW];

    assign win_open  = (state_q == WIN_OPEN);
    assign accept    = win_open && !strobe;
    assign win_close = accept && (elapsed >= close_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_IDLE;
            base_q  <= '0;
        end else if (strobe) begin
            state_q <= WIN_OPEN;
            base_q  <= fine_time + TW'(1);
        end else if (win_close) begin
            state_q <= WIN_IDLE;
        end
    end

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        localparam bit IN_LEGACY = (b < LEGACY_BINS);
        logic [TW-1:0] lo;
        logic [TW-1:0] hi;
        logic          enabled;

        assign lo      = cfg_bin_start[b*TW +: TW];
        assign hi      = cfg_bin_stop[b*TW +: TW];
        assign enabled = !cfg_legacy || IN_LEGACY;

        assign bin_hit[b] = accept && enabled &&
                            tick_in_span(PW'(elapsed), PW'(lo), PW'(hi));

        if (b == 0) begin : g_first
            assign bin_unsure[b] = 1'b0;
        end else begin : g_later
            assign bin_unsure[b] = tick_in_unsure(PW'(elapsed), PW'(lo), PW'(cfg_unsure_len));
        end
    end

    // No bin can match while the window is idle
    AST_IDLE_NO_BIN: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_IDLE) |-> (bin_hit == '0)); // R6

    // After a close the window is idle on the next cycle
    AST_CLOSE_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
        win_close |=> !win_open); // R7

endmodule

// File: rtl/dbe_occ_accum.sv
module dbe_occ_accum #(
    parameter int NUM_WIRES = 12,
    parameter int NUM_BINS  = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          strobe,
    input  logic                          win_close,
    input  logic [NUM_WIRES-1:0]          rise,
    input  logic [NUM_BINS-1:0]           bin_hit,
    input  logic [NUM_BINS-1:0]           bin_unsure,
    output logic [NUM_BINS*NUM_WIRES-1:0] occ_word,
    output logic                          occ_valid
);

    logic [NUM_BINS-1:0][NUM_WIRES-1:0] acc_q;
    logic [NUM_BINS-1:0][NUM_WIRES-1:0] blocked;
    logic [NUM_BINS-1:0][NUM_WIRES-1:0] set_bits;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        if (b == 0) begin : g_first
            assign blocked[b] = '0;
        end else begin : g_later
            // Wire already present in the previous bin and edge in the uncertain interval
            assign blocked[b] = {NUM_WIRES{bin_unsure[b]}} & acc_q[b-1];

            AST_UNSURE_DROP: assert property (@(posedge clk) disable iff (rst)
                (!strobe && bin_hit[b] && bin_unsure[b])
                |=> ((acc_q[b] & ~$past(acc_q[b]) & $past(acc_q[b-1])) == '0)); // R5
        end
        assign set_bits[b] = rise & {NUM_WIRES{bin_hit[b]}} & ~blocked[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (strobe) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q | set_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_word  <= '0;
            occ_valid <= 1'b0;
        end else begin
            occ_valid <= win_close;
            if (win_close) begin
                occ_word <= acc_q;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        occ_valid |=> !occ_valid); // R7

    AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (acc_q == '0)); // R9

endmodule

// File: rtl/drift_bin_encoder.sv
module drift_bin_encoder
    import drift_bin_pkg::*;
#(
    parameter int NUM_WIRES = 12,
    parameter int NUM_BINS  = 6,
    parameter int TW        = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_legacy,
    input  logic [NUM_BINS*TW-1:0]        cfg_bin_start,
    input  logic [NUM_BINS*TW-1:0]        cfg_bin_stop,
    input  logic [TW-1:0]                 cfg_unsure_len,
    input  logic [TW-1:0]                 fine_time,
    input  logic                          xing_strobe,
    input  logic [NUM_WIRES-1:0]          wire_hit,
    output logic [NUM_BINS*NUM_WIRES-1:0] occ_word,
    output logic                          occ_valid
);

    localparam int OCC_W  = NUM_BINS * NUM_WIRES;
    localparam int LEG_W  = LEGACY_BINS * NUM_WIRES;

    logic [NUM_WIRES-1:0] rise;
    logic                 win_open;
    logic                 win_close;
    logic [NUM_BINS-1:0]  bin_hit;
    logic [NUM_BINS-1:0]  bin_unsure;

    dbe_hit_sync #(
        .NUM_WIRES (NUM_WIRES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (wire_hit),
        .rise   (rise)
    );

    dbe_bin_window #(
        .NUM_BINS (NUM_BINS),
        .TW       (TW)
    ) u_window (
        .clk            (clk),
        .rst            (rst),
        .strobe         (xing_strobe),
        .cfg_legacy     (cfg_legacy),
        .fine_time      (fine_time),
        .cfg_bin_start  (cfg_bin_start),
        .cfg_bin_stop   (cfg_bin_stop),
        .cfg_unsure_len (cfg_unsure_len),
        .win_open       (win_open),
        .win_close      (win_close),
        .bin_hit        (bin_hit),
        .bin_unsure     (bin_unsure)
    );

    dbe_occ_accum #(
        .NUM_WIRES (NUM_WIRES),
        .NUM_BINS  (NUM_BINS)
    ) u_accum (
        .clk        (clk),
        .rst        (rst),
        .strobe     (xing_strobe),
        .win_close  (win_close),
        .rise       (rise),
        .bin_hit    (bin_hit),
        .bin_unsure (bin_unsure),
        .occ_word   (occ_word),
        .occ_valid  (occ_valid)
    );

    // Remembers whether any crossing has been seen since reset
    logic seen_strobe_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_strobe_q <= 1'b0;
        end else if (xing_strobe) begin
            seen_strobe_q <= 1'b1;
        end
    end

    AST_VALID_NEEDS_XING: assert property (@(posedge clk) disable iff (rst)
        occ_valid |-> seen_strobe_q); // R7

    AST_LEGACY_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (occ_valid && cfg_legacy) |-> (occ_word[OCC_W-1:LEG_W] == '0)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!occ_valid && (occ_word == '0))); // R1

    // Unused in assertions otherwise; keep window state observable for the checker above
    AST_OPEN_BEFORE_CLOSE: assert property (@(posedge clk) disable iff (rst)
        win_close |-> win_open); // R7

endmodule

// File: tb/drift_bin_encoder_tb.sv
module drift_bin_encoder_tb;

    localparam int NW = 12;
    localparam int NB = 6;
    localparam int TW = 8;
    localparam int UN = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst;
    logic             cfg_legacy;
    logic [NB*TW-1:0] cfg_bin_start;
    logic [NB*TW-1:0] cfg_bin_stop;
    logic [TW-1:0]    cfg_unsure_len;
    logic [TW-1:0]    fine_time;
    logic             xing_strobe;
    logic [NW-1:0]    wire_hit;
    logic [NB*NW-1:0] occ_word;
    logic             occ_valid;

    drift_bin_encoder #(.NUM_WIRES(NW), .NUM_BINS(NB), .TW(TW)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .cfg_legacy     (cfg_legacy),
        .cfg_bin_start  (cfg_bin_start),
        .cfg_bin_stop   (cfg_bin_stop),
        .cfg_unsure_len (cfg_unsure_len),
        .fine_time      (fine_time),
        .xing_strobe    (xing_strobe),
        .wire_hit       (wire_hit),
        .occ_word       (occ_word),
        .occ_valid      (occ_valid)
    );

    // Free-running fine-time count, started near the top so it wraps (R4)
    always @(posedge clk) begin
        if (rst) fine_time <= 8'd200;
        else     fine_time <= fine_time + 8'd1;
    end

    int bin_lo [NB] = '{4, 10, 16, 22, 28, 34};
    int bin_hi [NB] = '{10, 16, 22, 28, 34, 40};

    int n_checks = 0;
    int n_fail   = 0;
    int cur_tick = 0;
    logic [NW-1:0] held_mask = '0;

    logic [NB*NW-1:0] exp_word_q [$];
    int               exp_tick_q [$];
    string            exp_tag_q  [$];

    int ev_w [$];
    int ev_t [$];
    int ev_d [$];

    task automatic report(input bit ok, input string req, input string what,
                          input logic [NB*NW-1:0] act, input logic [NB*NW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic add_ev(input int w, input int t, input int d);
        ev_w.push_back(w);
        ev_t.push_back(t);
        ev_d.push_back(d);
    endtask

    task automatic clear_ev();
        ev_w.delete();
        ev_t.delete();
        ev_d.delete();
    endtask

    // Reference occupancy built from the requirements; events are listed in tick order
    function automatic logic [NB*NW-1:0] model_word(input bit legacy);
        logic [NB*NW-1:0] m;
        int nb;
        int close_t;
        m = '0;
        nb = legacy ? 2 : NB;
        close_t = bin_hi[nb-1];
        foreach (ev_t[i]) begin
            if (ev_t[i] < close_t) begin
                for (int b = 0; b < nb; b++) begin
                    if (ev_t[i] >= bin_lo[b] && ev_t[i] < bin_hi[b]) begin
                        if (!(b > 0 && ev_t[i] < bin_lo[b] + UN && m[(b-1)*NW + ev_w[i]]))
                            m[b*NW + ev_w[i]] = 1'b1;
                    end
                end
            end
        end
        return m;
    endfunction

    // Driver: pushes expectation, opens a window and plays the edges
    task automatic run_window(input bit legacy, input int limit_in, input bit expect_out,
                              input string tag);
        int close_t;
        int limit;
        cfg_legacy = legacy;
        close_t = legacy ? bin_hi[1] : bin_hi[NB-1];
        limit = (limit_in == 0) ? close_t + 4 : limit_in;
        if (expect_out) begin
            exp_word_q.push_back(model_word(legacy));
            exp_tick_q.push_back(close_t + 1);
            exp_tag_q.push_back(tag);
        end
        @(negedge clk);
        xing_strobe = 1'b1;
        @(negedge clk);
        xing_strobe = 1'b0;
        cur_tick = 0;
        for (int k = 0; k <= limit; k++) begin
            foreach (ev_t[i]) begin
                if (ev_t[i] - 2 == k)               wire_hit[ev_w[i]] = 1'b1;
                else if (ev_t[i] - 2 + ev_d[i] == k) wire_hit[ev_w[i]] = 1'b0;
            end
            @(negedge clk);
            cur_tick = k + 1;
        end
        wire_hit = held_mask;
    endtask

    // Monitor: pops expectations as words appear
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && occ_valid) begin
                if (exp_word_q.size() == 0) begin
                    report(1'b0, "R7 R9", "unexpected valid pulse", occ_word, '0);
                end else begin
                    logic [NB*NW-1:0] ew;
                    int et;
                    string tg;
                    ew = exp_word_q.pop_front();
                    et = exp_tick_q.pop_front();
                    tg = exp_tag_q.pop_front();
                    report(occ_word === ew, tg, "occupancy word", occ_word, ew);
                    report(cur_tick == et, "R7", "valid tick", (NB*NW)'(cur_tick), (NB*NW)'(et));
                end
            end
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst = 1'b1;
        cfg_legacy = 1'b0;
        xing_strobe = 1'b0;
        wire_hit = '0;
        cfg_unsure_len = 8'(UN);
        for (int b = 0; b < NB; b++) begin
            cfg_bin_start[b*TW +: TW] = 8'(bin_lo[b]);
            cfg_bin_stop[b*TW +: TW]  = 8'(bin_hi[b]);
        end
        repeat (4) @(negedge clk);
        report(!occ_valid && occ_word == '0, "R1", "in reset", occ_word, '0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        report(!occ_valid && occ_word == '0, "R1", "after reset", occ_word, '0);

        // Basic binning, boundaries, ignored edges (R3 R4 R6)
        clear_ev();
        add_ev(4, 2, 4);
        add_ev(0, 5, 4);
        add_ev(1, 12, 4);
        add_ev(5, 21, 4);
        add_ev(6, 22, 4);
        add_ev(2, 39, 4);
        add_ev(3, 40, 4);
        run_window(1'b0, 0, 1'b1, "R3 R4 R6");

        // Uncertain interval suppression (R5)
        clear_ev();
        add_ev(0, 5, 3);
        add_ev(1, 8, 3);
        add_ev(2, 10, 3);
        add_ev(0, 11, 3);
        add_ev(4, 12, 3);
        add_ev(1, 13, 3);
        add_ev(4, 16, 3);
        add_ev(3, 17, 3);
        run_window(1'b0, 0, 1'b1, "R5");

        // Legacy two-bin mode (R8)
        clear_ev();
        add_ev(0, 5, 3);
        add_ev(3, 6, 3);
        add_ev(3, 11, 3);
        add_ev(1, 12, 3);
        add_ev(2, 20, 3);
        run_window(1'b1, 0, 1'b1, "R8 R5");

        // Held level, long pulse, repeated edge in one bin (R2)
        held_mask = 12'h080;
        wire_hit = held_mask;
        repeat (3) @(negedge clk);
        clear_ev();
        add_ev(9, 4, 2);
        add_ev(8, 5, 20);
        add_ev(9, 8, 2);
        run_window(1'b0, 0, 1'b1, "R2");
        held_mask = '0;
        wire_hit = '0;
        repeat (3) @(negedge clk);

        // Restart while open discards the first window (R9)
        clear_ev();
        add_ev(0, 5, 3);
        run_window(1'b0, 12, 1'b0, "R9");
        clear_ev();
        add_ev(1, 6, 3);
        run_window(1'b0, 0, 1'b1, "R9");

        repeat (5) @(negedge clk);
        report(exp_word_q.size() == 0, "R7", "missing valid pulses",
               (NB*NW)'(exp_word_q.size()), '0);
        finish_up();
    end

endmodule